// File: doc/BRIEF.md
# Masked Event Interrupt Controller

This block holds the event flags and the interrupt enable mask of a network controller and turns them into dedicated interrupt lines. Hardware sources elsewhere in the controller pulse one bit of an event vector for one cycle. Each pulse latches the matching flag. Software reads the flags over a small register port. It acknowledges a flag by writing a one to that bit. It programs the enable mask with a plain store.

Thirteen interrupt lines leave the block. Each line carries the AND of one flag and its enable bit, with a fixed assignment of flags to lines that does not follow bit order. A store to the transmit control offset with bit 0 high raises the graceful-stop flag at once. This lets the transmit side acknowledge a stop request with no further handshake. A synchronous controller reset, driven by the surrounding logic, clears both registers.

Top module: `evtirq_ctrl`

## Requirements
- R1: `hw_evt[k]` high for one cycle sets event register bit 19+k on the next clock edge, for k = 0..12. From bit 31 down to bit 19 the flags are: heartbeat, babbling receive, babbling transmit, graceful stop, transmit frame, transmit buffer, receive frame, receive buffer, management, bus error, late collision, retry limit, underrun.
- R2: A write to offset 0x004 clears every event bit whose `wr_data` bit is one. All other event bits keep their value.
- R3: When a set pulse and a clear write hit the same event bit in the same cycle, the bit ends up set.
- R4: A write to offset 0x008 replaces all 32 bits of the mask register. A read of 0x008 returns that value.
- R5: Interrupt line index i = 0..12 is driven from these event bits: 27, 26, 19, 20, 25, 24, 23, 21, 31, 28, 22, 29, 30.
- R6: Each interrupt line equals the AND of its event bit and the mask bit at the same position. The line takes its new value one clock edge after the register value changes.
- R7: A write to offset 0x0C4 with `wr_data[0]` = 1 sets event bit 28 (graceful stop) on that edge. With `wr_data[0]` = 0 the write has no effect.
- R8: `ctl_rst` high at a clock edge clears both the event register and the mask register. Reset takes priority over any set in the same cycle.
- R9: A read of 0x004 returns the event register with bits 18..0 reading zero. Any offset other than 0x004 and 0x008 reads zero.
- R10: Writes to offsets other than 0x004, 0x008 and 0x0C4 change neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_rst | input | 1 | Synchronous controller reset, clears both registers |
| hw_evt | input | 13 | One-cycle event pulses; bit k targets event bit 19+k |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 10 | Write byte offset |
| wr_data | input | 32 | Write data |
| rd_addr | input | 10 | Read byte offset |
| rd_data | output | 32 | Read data, combinational from `rd_addr` |
| irq_line | output | 13 | Dedicated interrupt lines |

## Verification
Flag and mask updates appear on `rd_data` right after the clock edge that captures the write or pulse, so the bench reads them in the half cycle that follows. The interrupt lines trail the registers by exactly one more edge. Each line check is therefore made twice: once right after the flag edge, where the line must still be low, and once a cycle later, where it must be high. Inputs change on falling edges and outputs are sampled there, so no reading falls on an active edge.

// File: rtl/evtirq_pkg.sv
package evtirq_pkg;

  localparam int NUM_EVT  = 13;
  localparam int EVT_LSB  = 19;
  localparam int REG_W    = 32;
  localparam int GSTOP_IX = 9;   // flag index of graceful stop (register bit 28)

  typedef logic [NUM_EVT-1:0] evt_vec_t;

  // Flag index (register bit minus EVT_LSB) that feeds each interrupt line.
  function automatic int line_src(input int line);
    case (line)
      0:       return 8;   // transmit frame
      1:       return 7;   // transmit buffer
      2:       return 0;   // underrun
      3:       return 1;   // retry limit
      4:       return 6;   // receive frame
      5:       return 5;   // receive buffer
      6:       return 4;   // management
      7:       return 2;   // late collision
      8:       return 12;  // heartbeat
      9:       return 9;   // graceful stop
      10:      return 3;   // bus error
      11:      return 10;  // babbling transmit
      default: return 11;  // babbling receive
    endcase
  endfunction

  // Set has priority over clear.
  function automatic evt_vec_t flag_next(input evt_vec_t cur,
                                         input evt_vec_t set_v,
                                         input evt_vec_t clr_v);
    return (cur & ~clr_v) | set_v;
  endfunction

  // Place the flag vector into its register bit positions.
  function automatic logic [REG_W-1:0] flags_to_reg(input evt_vec_t f);
    logic [REG_W-1:0] r;
    r = '0;
    r[EVT_LSB +: NUM_EVT] = f;
    return r;
  endfunction

endpackage

// File: rtl/evtirq_flags.sv
module evtirq_flags
  import evtirq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     ctl_rst,
  input  evt_vec_t set_vec,
  input  evt_vec_t clr_vec,
  output evt_vec_t flags_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else if (ctl_rst) begin
      flags_q <= '0;
    end else begin
      flags_q <= flag_next(flags_q, set_vec, clr_vec);
    end
  end

endmodule

// File: rtl/evtirq_mask.sv
module evtirq_mask #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ctl_rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] mask_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (ctl_rst) begin
      mask_q <= '0;
    end else if (load) begin
      mask_q <= load_val;
    end
  end

endmodule

// File: rtl/evtirq_lines.sv
module evtirq_lines
  import evtirq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  evt_vec_t flags_q,
  input  evt_vec_t en_vec,
  output logic [NUM_EVT-1:0] line_q
);

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_line
    localparam int SRC = line_src(i);
    logic act;
    assign act = flags_q[SRC] & en_vec[SRC];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) line_q[i] <= 1'b0;
      else        line_q[i] <= act;
    end
  end

endmodule

// File: rtl/evtirq_ctrl.sv
module evtirq_ctrl
  import evtirq_pkg::*;
#(
  parameter int               ADDR_W    = 10,
  parameter logic [ADDR_W-1:0] OFS_EVENT = 10'h004,
  parameter logic [ADDR_W-1:0] OFS_MASK  = 10'h008,
  parameter logic [ADDR_W-1:0] OFS_TXCTL = 10'h0C4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_rst,
  input  logic [NUM_EVT-1:0] hw_evt,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [REG_W-1:0]  rd_data,
  output logic [NUM_EVT-1:0] irq_line
);

  // Named internal events, also observed by the checker.
  logic     wr_event, wr_mask, gstop_req;
  evt_vec_t set_vec, clr_vec, ev_flags, en_vec;
  logic [REG_W-1:0] mask_q;

  assign wr_event  = wr_en && (wr_addr == OFS_EVENT);
  assign wr_mask   = wr_en && (wr_addr == OFS_MASK);
  assign gstop_req = wr_en && (wr_addr == OFS_TXCTL) && wr_data[0];

  assign clr_vec = wr_event ? wr_data[EVT_LSB +: NUM_EVT] : '0;

  always_comb begin
    set_vec = hw_evt;
    set_vec[GSTOP_IX] = hw_evt[GSTOP_IX] | gstop_req;
  end

  evtirq_flags u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctl_rst (ctl_rst),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .flags_q (ev_flags)
  );

  evtirq_mask #(.W(REG_W)) u_mask (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl_rst  (ctl_rst),
    .load     (wr_mask),
    .load_val (wr_data),
    .mask_q   (mask_q)
  );

  assign en_vec = mask_q[EVT_LSB +: NUM_EVT];

  evtirq_lines u_lines (
    .clk     (clk),
    .rst_n   (rst_n),
    .flags_q (ev_flags),
    .en_vec  (en_vec),
    .line_q  (irq_line)
  );

  always_comb begin
    if (rd_addr == OFS_EVENT)     rd_data = flags_to_reg(ev_flags);
    else if (rd_addr == OFS_MASK) rd_data = mask_q;
    else                          rd_data = '0;
  end

endmodule

// File: rtl/evtirq_ctrl_chk.sv
module evtirq_ctrl_chk
  import evtirq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              ctl_rst,
  input logic              wr_mask,
  input logic              gstop_req,
  input logic [REG_W-1:0]  wr_data,
  input evt_vec_t          set_vec,
  input evt_vec_t          clr_vec,
  input evt_vec_t          ev_flags,
  input logic [REG_W-1:0]  mask_q,
  input logic [NUM_EVT-1:0] irq_line
);

  // R1 / R3: every requested set lands, even against a clear.
  p_set_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_rst |=> ((ev_flags & $past(set_vec)) == $past(set_vec)));

  // R2: cleared bits that were not set at the same time go low.
  p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_rst && (clr_vec != '0)) |=> ((ev_flags & $past(clr_vec & ~set_vec)) == '0));

  // R2: untouched bits hold their value.
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_rst |=> ((ev_flags & $past(~clr_vec & ~set_vec)) ==
                  ($past(ev_flags) & $past(~clr_vec & ~set_vec))));

  // R4: mask store replaces the whole value.
  p_mask_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mask && !ctl_rst) |=> (mask_q == $past(wr_data)));

  // R7: transmit control write with bit 0 raises graceful stop.
  p_gstop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (gstop_req && !ctl_rst) |=> ev_flags[GSTOP_IX]);

  // R8: controller reset clears both registers.
  p_ctl_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rst |=> ((ev_flags == '0) && (mask_q == '0)));

  // R5 / R6: sample lines follow flag AND mask one edge later.
  p_line0_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_line[0] == $past(ev_flags[8] & mask_q[27])));
  p_line2_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_line[2] == $past(ev_flags[0] & mask_q[19])));
  p_line8_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_line[8] == $past(ev_flags[12] & mask_q[31])));
  p_line9_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_line[9] == $past(ev_flags[9] & mask_q[28])));

endmodule

bind evtirq_ctrl evtirq_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ctl_rst   (ctl_rst),
  .wr_mask   (wr_mask),
  .gstop_req (gstop_req),
  .wr_data   (wr_data),
  .set_vec   (set_vec),
  .clr_vec   (clr_vec),
  .ev_flags  (ev_flags),
  .mask_q    (mask_q),
  .irq_line  (irq_line)
);

// File: tb/evtirq_ctrl_bench.sv
module evtirq_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_rst = 1'b0;
  logic [12:0] hw_evt = '0;
  logic        wr_en = 1'b0;
  logic [9:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [9:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [12:0] irq_line;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // Register bit feeding each line (R5), written independently of the RTL.
  int line_bit [13] = '{27, 26, 19, 20, 25, 24, 23, 21, 31, 28, 22, 29, 30};

  always #2 clk = ~clk;  // 250 MHz

  evtirq_ctrl u_evtirq_ctrl (
    .clk(clk), .rst_n(rst_n), .ctl_rst(ctl_rst), .hw_evt(hw_evt),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq_line(irq_line)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    rd_addr = a;
    #0.5;
    d = rd_data;
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse(input logic [12:0] v);
    @(negedge clk);
    hw_evt = v;
    @(negedge clk);
    hw_evt = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(10'h004, d); chk("R8 reset event", d, 32'h0);
    rd(10'h008, d); chk("R8 reset mask", d, 32'h0);
    chk("R6 reset lines", {19'd0, irq_line}, 32'h0);
  endtask

  task automatic t_layout;
    logic [31:0] d;
    for (int k = 0; k < 13; k++) begin
      pulse(13'd1 << k);
      rd(10'h004, d); chk("R1 set bit", d, 32'd1 << (19 + k));
      idle(1);
      chk("R6 masked line stays low", {19'd0, irq_line}, 32'h0);
      wr(10'h004, 32'hFFFF_FFFF);
    end
  endtask

  task automatic t_w1c;
    logic [31:0] d;
    pulse(13'h1FFF);
    rd(10'h004, d); chk("R2 all set", d, 32'hFFF8_0000);
    wr(10'h004, 32'hAAAA_0000);
    rd(10'h004, d); chk("R2 partial clear", d, 32'h5550_0000 & 32'hFFF8_0000);
    wr(10'h004, 32'h0000_0000);
    rd(10'h004, d); chk("R2 zero write no change", d, 32'h5550_0000 & 32'hFFF8_0000);
    wr(10'h004, 32'hFFFF_FFFF);
    rd(10'h004, d); chk("R2 clear all", d, 32'h0);
  endtask

  task automatic t_set_wins;
    logic [31:0] d;
    pulse(13'h0003);  // bits 19,20
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 10'h004; wr_data = 32'h0018_0000; hw_evt = 13'h0001;
    @(negedge clk);
    wr_en = 1'b0; hw_evt = '0;
    rd(10'h004, d); chk("R3 set beats clear", d, 32'h0008_0000);
    wr(10'h004, 32'hFFFF_FFFF);
  endtask

  task automatic t_mask;
    logic [31:0] d;
    wr(10'h008, 32'hDEAD_BEEF);
    rd(10'h008, d); chk("R4 mask readback", d, 32'hDEAD_BEEF);
    wr(10'h008, 32'h1234_5678);
    rd(10'h008, d); chk("R4 mask replace", d, 32'h1234_5678);
    rd(10'h004, d); chk("R4 event untouched", d, 32'h0);
  endtask

  task automatic t_lines;
    wr(10'h008, 32'hFFFF_FFFF);
    for (int i = 0; i < 13; i++) begin
      pulse(13'd1 << (line_bit[i] - 19));
      chk("R6 line latency", {19'd0, irq_line}, 32'h0);
      idle(1);
      chk("R5 line map", {19'd0, irq_line}, 32'd1 << i);
      wr(10'h004, 32'hFFFF_FFFF);
      idle(1);
    end
    // Masked off: flag set, enable clear.
    wr(10'h008, 32'hFFFF_FFFF & ~(32'd1 << 25));
    pulse(13'd1 << 6);  // bit 25 -> line 4
    idle(1);
    chk("R6 mask gates line", {19'd0, irq_line}, 32'h0);
    wr(10'h008, 32'hFFFF_FFFF);
    idle(1);
    chk("R6 mask enables line", {19'd0, irq_line}, 32'h0000_0010);
    wr(10'h004, 32'hFFFF_FFFF);
    idle(1);
    chk("R6 line drops after clear", {19'd0, irq_line}, 32'h0);
  endtask

  task automatic t_gstop;
    logic [31:0] d;
    wr(10'h0C4, 32'hFFFF_FFFE);
    rd(10'h004, d); chk("R7 bit0 low no effect", d, 32'h0);
    wr(10'h0C4, 32'h0000_0001);
    rd(10'h004, d); chk("R7 graceful stop set", d, 32'h1000_0000);
    idle(1);
    chk("R7 graceful stop line", {19'd0, irq_line}, 32'h0000_0200);
    wr(10'h004, 32'hFFFF_FFFF);
    idle(1);
  endtask

  task automatic t_ctl_rst;
    logic [31:0] d;
    pulse(13'h1555);
    @(negedge clk);
    ctl_rst = 1'b1; hw_evt = 13'h0AAA;
    @(negedge clk);
    ctl_rst = 1'b0; hw_evt = '0;
    rd(10'h004, d); chk("R8 event cleared", d, 32'h0);
    rd(10'h008, d); chk("R8 mask cleared", d, 32'h0);
    idle(1);
    chk("R8 lines low", {19'd0, irq_line}, 32'h0);
  endtask

  task automatic t_decode;
    logic [31:0] d;
    wr(10'h008, 32'h0F0F_0F0F);
    pulse(13'h0010);
    wr(10'h010, 32'hFFFF_FFFF);
    wr(10'h00C, 32'hFFFF_FFFF);
    rd(10'h004, d); chk("R10 event unchanged", d, 32'h0080_0000);
    rd(10'h008, d); chk("R10 mask unchanged", d, 32'h0F0F_0F0F);
    rd(10'h00C, d); chk("R9 other offset reads zero", d, 32'h0);
    rd(10'h0C4, d); chk("R9 txctl reads zero", d, 32'h0);
    wr(10'h008, 32'h0007_FFFF);
    rd(10'h004, d); chk("R9 low event bits zero", d & 32'h0007_FFFF, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_layout();
    t_w1c();
    t_set_wins();
    t_mask();
    t_lines();
    t_gstop();
    t_ctl_rst();
    t_decode();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule